// File: doc/BRIEF.md
# Nine-Stage Interpolate-by-Eight CIC Filter

This block raises the sample rate of a signed 24-bit stream by a fixed factor of eight. Nine first-difference stages act on the low-rate samples. A zero-stuffing step then passes each difference result into a chain of nine running-sum stages, which run on every high-rate clock. All stages share one clock, which is the high (output) rate. The block takes one low-rate sample in every eighth cycle and delivers one 48-bit result on every cycle.

Each difference stage is one bit wider than the stage that feeds it, so the last one is 33 bits wide. Every running-sum stage is 48 bits wide and adds modulo 2^48 without saturation. If one of these registers wraps, the wrap cancels further down the chain, so the final result is exact. The DC gain is 8^9/8 = 2^24.

Top module: `cic_interpolator`

## Requirements
- R1: `in_ready` is high in the first clock cycle after reset is released, and from then on it is high in exactly one cycle out of every eight.
- R2: `in_valid` and `in_data` are sampled only in a cycle where `in_ready` is high. In every other cycle their values have no effect on `out_data`.
- R3: If `in_valid` is low in a cycle where `in_ready` is high, that slot is processed as a sample of value zero, whatever `in_data` holds.
- R4: Take a sample of value 1 accepted at clock edge e, with zero in every other slot. The output after edge e+17+k is h[k] for k = 0..63, where h holds the coefficients of (1+z^-1+...+z^-7)^9.
- R5: Let u[c] be the sample accepted at edge c, or 0 when edge c is not an accepting edge. The output after edge c is the sum over k of h[k]·u[c−17−k], taken modulo 2^48 as a two's-complement value.
- R6: A sustained full-scale negative input (0x800000) settles to 0x800000000000. A sustained maximum positive input (0x7FFFFF) settles to 0x7FFFFF000000. Both equal input × 2^24.
- R7: The running-sum stages wrap modulo 2^48 and never saturate. Under full-scale input, every output still matches R5 exactly.
- R8: A synchronous reset clears all stage state and the phase counter. While reset is high, `out_data` is 0 and `out_valid` is low. After reset, the output stays 0 until a nonzero sample is accepted.
- R9: `out_valid` goes high after the first clock edge with reset low and stays high on every cycle until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Low-rate sample present |
| in_ready | output | 1 | Slot open: the sample is taken at this edge |
| in_data | input | 24 | Signed low-rate sample |
| out_valid | output | 1 | High-rate result valid |
| out_data | output | 48 | Signed full-precision high-rate result |

## Verification
Some properties are checked on every cycle. These are the one-in-eight cadence of `in_ready` and the stability of the first difference stage while no slot is open. Also checked are that the stuffed value is nonzero only in the second phase of each period, the cleared outputs during reset, and `out_valid` after reset. Arithmetic exactness can only be shown by the bench scenarios. The bench compares each cycle against a convolution of the zero-stuffed input with the computed impulse coefficients. The scenarios cover an isolated impulse, skipped slots with junk data, mixed-sign samples and long full-scale runs of both signs. A final scenario applies reset while the chain holds large values.

// File: rtl/cic_interpolator.sv
module cic_interpolator #(
  parameter int IN_W   = 24,
  parameter int STAGES = 9,
  parameter int RATE   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   out_valid,
  output logic signed [IN_W+(STAGES-1)*$clog2(RATE)-1:0] out_data
);
  localparam int PH_W  = $clog2(RATE);
  localparam int OUT_W = IN_W + (STAGES-1)*PH_W;

  logic [PH_W-1:0]          phase;
  logic [STAGES-1:0]        cv_q;
  logic [STAGES:0]          cv;
  logic signed [IN_W-1:0]   sample;
  logic signed [OUT_W-1:0]  stuffed;

  assign in_ready = (phase == '0);
  assign sample   = in_valid ? in_data : '0;
  assign cv       = {cv_q, in_ready};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= '0;
      cv_q      <= '0;
      out_valid <= 1'b0;
    end else begin
      phase     <= (phase == PH_W'(RATE-1)) ? '0 : phase + 1'b1;
      cv_q      <= cv[STAGES-1:0];
      out_valid <= 1'b1;
    end
  end

  for (genvar k = 1; k <= STAGES; k++) begin : g_comb
    localparam int W = IN_W + k;
    logic signed [W-2:0] xin;
    logic signed [W-2:0] dly;
    logic signed [W-1:0] y;
    if (k == 1) begin : g_src
      assign xin = sample;
    end else begin : g_prev
      assign xin = g_comb[k-1].y;
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        dly <= '0;
        y   <= '0;
      end else if (cv[k-1]) begin
        dly <= xin;
        y   <= W'(xin) - W'(dly);
      end
    end
  end

  assign stuffed = cv[STAGES] ? OUT_W'(g_comb[STAGES].y) : '0;

  for (genvar k = 1; k <= STAGES; k++) begin : g_int
    logic signed [OUT_W-1:0] src;
    logic signed [OUT_W-1:0] acc;
    if (k == 1) begin : g_src
      assign src = stuffed;
    end else begin : g_prev
      assign src = g_int[k-1].acc;
    end
    always_ff @(posedge clk) begin
      if (rst) acc <= '0;
      else     acc <= acc + src;
    end
  end

  assign out_data = g_int[STAGES].acc;
endmodule

// File: rtl/cic_interpolator_chk.sv
module cic_interpolator_chk #(
  parameter int RATE  = 8,
  parameter int C1_W  = 25,
  parameter int OUT_W = 48
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic [OUT_W-1:0]        out_data,
  input logic [OUT_W-1:0]        stuffed,
  input logic [C1_W-1:0]         first_comb,
  input logic [$clog2(RATE)-1:0] phase
);
  localparam int PH_W = $clog2(RATE);

  logic [PH_W-1:0] gap;
  logic            rst_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)           gap <= PH_W'(RATE-1);
    else if (in_ready) gap <= '0;
    else               gap <= gap + 1'b1;
  end

  AST_READY_CADENCE: assert property (@(posedge clk) disable iff (rst)
    in_ready == (gap == PH_W'(RATE-1)));                                     // R1

  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> $stable(first_comb));                                      // R2

  AST_ZERO_STUFF: assert property (@(posedge clk) disable iff (rst)
    (stuffed != '0) |-> (phase == PH_W'(1)));                                // R5

  AST_VALID_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> out_valid);                                                     // R9

  always_ff @(posedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEAR: assert (out_data == '0 && !out_valid);                // R8
    end
  end
endmodule

bind cic_interpolator cic_interpolator_chk #(
  .RATE(RATE), .C1_W(IN_W+1), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .stuffed(stuffed), .first_comb(g_comb[1].y),
  .phase(phase)
);

// File: tb/cic_interpolator_tb.sv
module cic_interpolator_tb;
  localparam int IN_W = 24, STAGES = 9, RATE = 8, OUT_W = 48;
  localparam int LAT = 17, TAPS = STAGES*(RATE-1)+1, NV = 8;
  localparam logic [39:0] VEC [NV] = '{
    {1'b1, 24'h000001, 15'd1},
    {1'b0, 24'h000000, 15'd12},
    {1'b1, 24'h123456, 15'd1},
    {1'b1, 24'hFEDCBA, 15'd1},
    {1'b0, 24'h7FFFFF, 15'd3},
    {1'b1, 24'h000100, 15'd2},
    {1'b1, 24'h800000, 15'd25},
    {1'b1, 24'h7FFFFF, 15'd25}
  };

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [IN_W-1:0] in_data = '0;
  logic in_ready, out_valid;
  logic [OUT_W-1:0] out_data;
  longint h [TAPS];
  longint u [2048];
  int errors = 0, checks = 0, c = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cic_interpolator u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", req, c, act, exp);
    end
  endtask

  function automatic longint ref_out(input int cyc);
    longint s = 0;
    logic [OUT_W-1:0] t;
    for (int k = 0; k < TAPS; k++)
      if (cyc-LAT-k >= 0) s += h[k] * u[cyc-LAT-k];
    t = s[OUT_W-1:0];
    return longint'($signed(t));
  endfunction

  task automatic step(input bit v, input logic [IN_W-1:0] d, input string req);
    bit slot = (c % RATE == 0);
    longint exp, act;
    chk(in_ready == slot, "R1", longint'(in_ready), longint'(slot));
    if (slot) begin
      in_valid = v; in_data = d;
      u[c] = v ? longint'($signed(d)) : 0;
    end else begin
      in_valid = 1'b1; in_data = 24'h5A5A5A;   // R2 junk while not ready
      u[c] = 0;
    end
    @(posedge clk); @(negedge clk);
    act = longint'($signed(out_data));
    if (req == "R4" && c >= LAT && c < LAT+TAPS) exp = h[c-LAT];
    else exp = ref_out(c);
    chk(act == exp, req, act, exp);
    chk(out_valid == 1'b1, "R9", longint'(out_valid), 1);
    c++;
  endtask

  initial begin
    longint old [TAPS];
    for (int i = 0; i < TAPS; i++) h[i] = (i == 0) ? 1 : 0;
    for (int s = 0; s < STAGES; s++) begin
      for (int i = 0; i < TAPS; i++) old[i] = h[i];
      for (int i = 0; i < TAPS; i++) begin
        h[i] = 0;
        for (int j = 0; j < RATE; j++) if (i-j >= 0) h[i] += old[i-j];
      end
    end
    for (int i = 0; i < 2048; i++) u[i] = 0;

    repeat (3) @(negedge clk);
    chk(out_data == '0 && !out_valid, "R8", longint'(out_data), 0);
    rst = 1'b0;
    c = 0;
    for (int e = 0; e < NV; e++) begin
      for (int r = 0; r < int'(VEC[e][14:0]); r++)
        for (int p = 0; p < RATE; p++)
          step(VEC[e][39], VEC[e][38:15],
               (e < 2) ? "R4" : (e >= 6) ? "R7" : (VEC[e][39] ? "R5" : "R3"));
      if (e == 6) chk(out_data == 48'h800000000000, "R6",
                      longint'($signed(out_data)), longint'(48'h800000000000) - (64'sd1 <<< 48));
      if (e == 7) chk(out_data == 48'h7FFFFF000000, "R6",
                      longint'(out_data), longint'(48'h7FFFFF000000));
    end

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(out_data == '0, "R8", longint'($signed(out_data)), 0);
    chk(!out_valid, "R8", longint'(out_valid), 0);
    rst = 1'b0;
    c = 0;
    for (int i = 0; i < 2048; i++) u[i] = 0;
    for (int i = 0; i < 3*RATE; i++) step(1'b0, 24'h7FFFFF, "R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R5 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule